// File: doc/BRIEF.md
# Packet-Engine Integer ALU

This block is the single-cycle integer execute stage of a RISC core tuned for packet processing. Each cycle it may accept one decoded operation: a 7-bit operation select, two 32-bit register operands, a 16-bit immediate and a 5-bit destination register index. One clock later it presents the 32-bit result, the destination index and a write-enable for the register file, all qualified by a valid strobe.

Besides the usual add, subtract, bitwise logic and set-less-than operations with register or immediate operands, it offers two operations suited to header editing. The first is a split add that sums the two 16-bit halves independently, with no carry between them. The second is an AND with an immediate whose upper half is forced to ones, so that only the low half of the operand is masked.

The operation select works as follows. When bit 6 is 0, bits 5:0 hold a register-register function code. When bit 6 is 1, bits 5:0 hold an immediate-form code, and the immediate takes the place of `opb`.

Top module: `pkt_alu`

## Requirements
- R1: While `rst` is high at a clock edge, `out_vld`, `out_wen` and `out_illegal` are low after that edge.
- R2: `out_vld` equals `in_vld` delayed by exactly one clock, and the result, destination and flags belong to the operation accepted on that previous edge.
- R3: The register-register codes 32 (add), 33 (add unsigned), 34 (subtract) and 35 (subtract unsigned) return the sum or difference modulo 2^32. The signed and unsigned codes give identical results, and no overflow is flagged.
- R4: The codes 36, 37, 38 and 39 return opa AND opb, opa OR opb, opa XOR opb and NOT(opa OR opb).
- R5: Code 41 returns opa[15:0]+opb[15:0] in bits 15:0 and opa[31:16]+opb[31:16] in bits 31:16. Each half wraps modulo 2^16, and no carry passes from the low half to the high half.
- R6: Code 42 returns 1 if opa is less than opb as signed numbers, else 0. Code 43 does the same as unsigned numbers.
- R7: The immediate codes 8 (add), 9 (add unsigned) and 10 (set-less-than signed) use the immediate sign-extended to 32 bits. Code 11 compares opa as unsigned against the sign-extended immediate.
- R8: The immediate codes 12 (AND), 13 (OR) and 14 (XOR) use the immediate zero-extended to 32 bits.
- R9: Immediate code 44 returns opa AND {16'hFFFF, imm}: the upper half of opa passes unchanged.
- R10: `out_wen` is low whenever the destination index is 0.
- R11: Any other select value yields `out_res` = 0 and `out_wen` low, and raises `out_illegal` for that one result cycle.
- R12: While `out_vld` is low, `out_wen` and `out_illegal` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | An operation is presented this cycle |
| op_sel | input | 7 | Operation select: bit 6 picks immediate form, bits 5:0 the code |
| opa | input | 32 | First register operand |
| opb | input | 32 | Second register operand (unused by immediate forms) |
| imm | input | 16 | Immediate field |
| dst | input | 5 | Destination register index |
| out_vld | output | 1 | Result valid |
| out_res | output | 32 | Result |
| out_dst | output | 5 | Destination register index of the result |
| out_wen | output | 1 | Register write-enable |
| out_illegal | output | 1 | Unrecognised operation select |

## Verification
Every result is due exactly one clock after the edge at which `in_vld` was sampled, because the unit holds one register stage between inputs and outputs. The bench drives inputs just after the rising edge. It forms its expectation for the next output at each rising edge from the same inputs the design samples, and compares at the falling edge. Each cycle therefore checks `out_vld`, and a valid cycle also checks the result, destination, write-enable and illegal flag against the value predicted one edge earlier. Reset cycles and idle cycles are compared the same way, which covers the reset clearing and the qualifying of the strobes.

// File: rtl/pkt_alu.sv
module pkt_alu #(
  parameter int W  = 32,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_vld,
  input  logic [6:0]    op_sel,
  input  logic [W-1:0]  opa,
  input  logic [W-1:0]  opb,
  input  logic [W/2-1:0] imm,
  input  logic [RW-1:0] dst,
  output logic          out_vld,
  output logic [W-1:0]  out_res,
  output logic [RW-1:0] out_dst,
  output logic          out_wen,
  output logic          out_illegal
);
  localparam int H = W / 2;

  localparam logic [6:0] C_ADD   = 7'd32;
  localparam logic [6:0] C_ADDU  = 7'd33;
  localparam logic [6:0] C_SUB   = 7'd34;
  localparam logic [6:0] C_SUBU  = 7'd35;
  localparam logic [6:0] C_AND   = 7'd36;
  localparam logic [6:0] C_OR    = 7'd37;
  localparam logic [6:0] C_XOR   = 7'd38;
  localparam logic [6:0] C_NOR   = 7'd39;
  localparam logic [6:0] C_HADD  = 7'd41;
  localparam logic [6:0] C_SLT   = 7'd42;
  localparam logic [6:0] C_SLTU  = 7'd43;
  localparam logic [6:0] C_ADDI  = 7'd64 + 7'd8;
  localparam logic [6:0] C_ADDIU = 7'd64 + 7'd9;
  localparam logic [6:0] C_SLTI  = 7'd64 + 7'd10;
  localparam logic [6:0] C_SLTIU = 7'd64 + 7'd11;
  localparam logic [6:0] C_ANDI  = 7'd64 + 7'd12;
  localparam logic [6:0] C_ORI   = 7'd64 + 7'd13;
  localparam logic [6:0] C_XORI  = 7'd64 + 7'd14;
  localparam logic [6:0] C_ANDOI = 7'd64 + 7'd44;

  wire [W-1:0] simm = {{H{imm[H-1]}}, imm};
  wire [W-1:0] zimm = {{H{1'b0}}, imm};
  wire [H-1:0] lo_sum = opa[H-1:0] + opb[H-1:0];
  wire [H-1:0] hi_sum = opa[W-1:H] + opb[W-1:H];

  logic [W-1:0] res_d;
  logic         legal;

  always_comb begin
    legal = 1'b1;
    res_d = '0;
    case (op_sel)
      C_ADD, C_ADDU:   res_d = opa + opb;
      C_SUB, C_SUBU:   res_d = opa - opb;
      C_AND:           res_d = opa & opb;
      C_OR:            res_d = opa | opb;
      C_XOR:           res_d = opa ^ opb;
      C_NOR:           res_d = ~(opa | opb);
      C_HADD:          res_d = {hi_sum, lo_sum};
      C_SLT:           res_d = {{(W-1){1'b0}}, $signed(opa) < $signed(opb)};
      C_SLTU:          res_d = {{(W-1){1'b0}}, opa < opb};
      C_ADDI, C_ADDIU: res_d = opa + simm;
      C_SLTI:          res_d = {{(W-1){1'b0}}, $signed(opa) < $signed(simm)};
      C_SLTIU:         res_d = {{(W-1){1'b0}}, opa < simm};
      C_ANDI:          res_d = opa & zimm;
      C_ORI:           res_d = opa | zimm;
      C_XORI:          res_d = opa ^ zimm;
      C_ANDOI:         res_d = opa & {{H{1'b1}}, imm};
      default:         legal = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld     <= 1'b0;
      out_wen     <= 1'b0;
      out_illegal <= 1'b0;
      out_res     <= '0;
      out_dst     <= '0;
    end else begin
      out_vld     <= in_vld;
      out_wen     <= in_vld & legal & (|dst);
      out_illegal <= in_vld & ~legal;
      if (in_vld) begin
        out_res <= legal ? res_d : '0;
        out_dst <= dst;
      end
    end
  end

  AST_RST_CLEAR: assert property (@(posedge clk) rst |=> (!out_vld && !out_wen && !out_illegal)); // R1
  AST_VLD_FOLLOW: assert property (@(posedge clk) disable iff (rst) in_vld |=> out_vld); // R2
  AST_IDLE_FOLLOW: assert property (@(posedge clk) disable iff (rst) !in_vld |=> !out_vld); // R2
  AST_HALF_NOCARRY: assert property (@(posedge clk) disable iff (rst)
    (in_vld && op_sel == C_HADD) |=>
      (out_res[H-1:0] == $past(opa[H-1:0]) + $past(opb[H-1:0]) &&
       out_res[W-1:H] == $past(opa[W-1:H]) + $past(opb[W-1:H]))); // R5
  AST_ANDOI_UPPER: assert property (@(posedge clk) disable iff (rst)
    (in_vld && op_sel == C_ANDOI) |=> out_res[W-1:H] == $past(opa[W-1:H])); // R9
  AST_NO_R0_WRITE: assert property (@(posedge clk) disable iff (rst) out_wen |-> out_dst != '0); // R10
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> (!out_wen && out_res == '0)); // R11
  AST_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> (!out_wen && !out_illegal)); // R12
endmodule

// File: tb/tb_pkt_alu.sv
module tb_pkt_alu;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_vld = 1'b0;
  logic [6:0]  op_sel = '0;
  logic [31:0] opa = '0, opb = '0;
  logic [15:0] imm = '0;
  logic [4:0]  dst = '0;
  logic        out_vld, out_wen, out_illegal;
  logic [31:0] out_res;
  logic [4:0]  out_dst;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_alu dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .op_sel(op_sel), .opa(opa), .opb(opb),
    .imm(imm), .dst(dst), .out_vld(out_vld), .out_res(out_res), .out_dst(out_dst),
    .out_wen(out_wen), .out_illegal(out_illegal)
  );

  logic        e_vld = 0, e_wen = 0, e_ill = 0, e_rst = 1;
  logic [31:0] e_res = 0;
  logic [4:0]  e_dst = 0;
  string       e_tag = "R1";

  function automatic void model(input logic [6:0] op, input logic [31:0] a, b,
                                input logic [15:0] i, output logic [31:0] r,
                                output bit ok, output string tag);
    longint sa, sb, si;
    logic [31:0] se;
    se = {{16{i[15]}}, i};
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    si = longint'($signed(se));
    ok = 1;
    r = 0;
    tag = "R11";
    case (op)
      7'd32, 7'd33: begin r = 32'((64'(a) + 64'(b)) % 64'h1_0000_0000); tag = "R3"; end
      7'd34, 7'd35: begin r = 32'((64'h1_0000_0000 + 64'(a) - 64'(b)) % 64'h1_0000_0000); tag = "R3"; end
      7'd36: begin r = a & b; tag = "R4"; end
      7'd37: begin r = a | b; tag = "R4"; end
      7'd38: begin r = a ^ b; tag = "R4"; end
      7'd39: begin r = ~(a | b); tag = "R4"; end
      7'd41: begin
        r[15:0]  = 16'((int'(a[15:0]) + int'(b[15:0])) % 65536);
        r[31:16] = 16'((int'(a[31:16]) + int'(b[31:16])) % 65536);
        tag = "R5";
      end
      7'd42: begin r = (sa < sb) ? 1 : 0; tag = "R6"; end
      7'd43: begin r = (64'(a) < 64'(b)) ? 1 : 0; tag = "R6"; end
      7'd72, 7'd73: begin r = 32'(sa + si); tag = "R7"; end
      7'd74: begin r = (sa < si) ? 1 : 0; tag = "R7"; end
      7'd75: begin r = (64'(a) < 64'(se)) ? 1 : 0; tag = "R7"; end
      7'd76: begin r = a & {16'h0, i}; tag = "R8"; end
      7'd77: begin r = a | {16'h0, i}; tag = "R8"; end
      7'd78: begin r = a ^ {16'h0, i}; tag = "R8"; end
      7'd108: begin r = {a[31:16], a[15:0] & i}; tag = "R9"; end
      default: ok = 0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [31:0] r;
    bit ok;
    string t;
    model(op_sel, opa, opb, imm, r, ok, t);
    e_rst <= rst;
    if (rst) begin
      e_vld <= 0; e_wen <= 0; e_ill <= 0; e_tag <= "R1";
    end else begin
      e_vld <= in_vld;
      if (in_vld) begin
        e_res <= ok ? r : 32'h0;
        e_dst <= dst;
        e_wen <= ok && dst != 0;
        e_ill <= !ok;
        e_tag <= (ok && dst == 0) ? "R10" : t;
      end else begin
        e_wen <= 0; e_ill <= 0; e_tag <= "R12";
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk(e_rst ? "R1" : "R2", "out_vld", 32'(out_vld), 32'(e_vld));
      if (e_vld) begin
        chk(e_tag, "out_res", out_res, e_res);
        chk("R2", "out_dst", 32'(out_dst), 32'(e_dst));
        chk(e_tag, "out_wen", 32'(out_wen), 32'(e_wen));
        chk(e_tag, "out_illegal", 32'(out_illegal), 32'(e_ill));
      end else begin
        chk(e_rst ? "R1" : "R12", "out_wen", 32'(out_wen), 32'h0);
        chk(e_rst ? "R1" : "R12", "out_illegal", 32'(out_illegal), 32'h0);
      end
    end
  end

  task automatic issue(input logic [6:0] op, input logic [31:0] a, b,
                       input logic [15:0] i, input logic [4:0] d);
    @(posedge clk);
    #1;
    in_vld = 1; op_sel = op; opa = a; opb = b; imm = i; dst = d;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
      in_vld = 0; op_sel = $urandom_range(0, 127); opa = $urandom; dst = $urandom;
    end
  endtask

  initial begin
    logic [6:0] ops[17];
    ops = '{7'd32, 7'd33, 7'd34, 7'd35, 7'd36, 7'd37, 7'd38, 7'd39, 7'd41, 7'd42,
            7'd43, 7'd72, 7'd73, 7'd74, 7'd75, 7'd76, 7'd108};
    repeat (3) @(posedge clk);
    #1 rst = 0;
    issue(7'd32, 32'hFFFF_FFFF, 32'h1, 16'h0, 5'd3);        // R3 wrap
    issue(7'd35, 32'h0, 32'h1, 16'h0, 5'd4);                // R3 borrow
    issue(7'd39, 32'h0F0F_0000, 32'h00F0_00FF, 16'h0, 5'd5);// R4
    issue(7'd41, 32'h0001_FFFF, 32'h0001_0001, 16'h0, 5'd6);// R5 no carry
    issue(7'd41, 32'hFFFF_8000, 32'h0002_8000, 16'h0, 5'd7);// R5 both wrap
    issue(7'd42, 32'hFFFF_FFFF, 32'h1, 16'h0, 5'd8);        // R6 signed
    issue(7'd43, 32'hFFFF_FFFF, 32'h1, 16'h0, 5'd9);        // R6 unsigned
    issue(7'd72, 32'd10, 32'h0, 16'hFFFF, 5'd10);           // R7 addi -1
    issue(7'd74, 32'hFFFF_FFF0, 32'h0, 16'hFFFF, 5'd11);    // R7 slti
    issue(7'd75, 32'd5, 32'h0, 16'hFFFF, 5'd12);            // R7 sltiu vs 0xFFFFFFFF
    issue(7'd77, 32'h0, 32'h0, 16'h8000, 5'd13);            // R8 zero-extend
    issue(7'd78, 32'hFFFF_FFFF, 32'h0, 16'h8001, 5'd14);    // R8
    issue(7'd108, 32'hABCD_1234, 32'h0, 16'h00F0, 5'd15);   // R9
    issue(7'd37, 32'h1234, 32'h1, 16'h0, 5'd0);             // R10
    issue(7'd40, 32'h1234, 32'h1, 16'h0, 5'd16);            // R11
    issue(7'd0, 32'h1, 32'h1, 16'h0, 5'd0);                 // R11 with r0
    idle(3);                                                // R12
    issue(7'd76, 32'h1234_5678, 32'h0, 16'h0FF0, 5'd17);    // R8
    idle(1);
    for (int n = 0; n < 400; n++) begin
      logic [6:0] op;
      op = ($urandom_range(0, 9) == 0) ? 7'($urandom_range(0, 127)) : ops[$urandom_range(0, 16)];
      if ($urandom_range(0, 5) == 0) idle(1);
      issue(op, $urandom, ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : $urandom,
            16'($urandom), 5'($urandom));
    end
    idle(2);
    @(posedge clk);
    #1 rst = 1;                                             // R1 mid-run reset
    in_vld = 1; op_sel = 7'd32;
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    #1 rst = 0; in_vld = 0;
    idle(2);
    @(negedge clk);
    #1;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule